// File: doc/BRIEF.md
# Half-Bridge Interlock and Deadtime Generator

This block sits between a controller's two switching commands, one for the upper switch and one for the lower switch of a half-bridge, and the two gate-enable outputs that go to the analog drive stage. It synchronizes the commands and two undervoltage flags into its clock domain. It refuses to drive both switches at once. Whenever any gate enable turns off, it holds off every turn-on for a programmable number of clock cycles. A third output enables the bootstrap-charging switch and moves with the lower gate.

Both undervoltage flags arrive already debounced. The lower-supply flag shuts down both gates, and the floating-supply flag shuts down only the upper gate. Once a flag clears, a gate comes back only after a new rising edge of its own command, so a command that was held high during the fault cannot switch the bridge unexpectedly. All pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and nothing can apply back-pressure to it. At the default 200 MHz clock, the default count of 94 cycles gives a deadtime of 470 ns. The 325 to 615 ns window corresponds to 65 to 123 cycles.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: The gate outputs are active high and in phase with the commands. With only `cmd_hi` high, `gate_hi` is driven. With only `cmd_lo` high, `gate_lo` is driven. With both commands high or both low, both gates are low. A command that stays high through a both-high conflict takes its gate back once the conflict ends.
- R2: When no deadtime is pending, a gate changes on the third rising clock edge after its command changes: two synchronizer stages, then the output register.
- R3: `gate_hi` and `gate_lo` are never high in the same cycle.
- R4: After either gate falls, neither gate rises until it has been low for at least `DT_CYCLES` full cycles. In a direct hand-off from one side to the other, the incoming gate rises exactly `DT_CYCLES` cycles after the outgoing gate falls.
- R5: If a command drops before the deadtime ends, its pending turn-on is cancelled and the gate never rises.
- R6: While `rst_n` is low, all outputs are low. After reset is released, no gate rises within the first `DT_CYCLES` cycles.
- R7: While `uv_lo` is high, both gates are low.
- R8: While `uv_hi` is high, `gate_hi` is low and `gate_lo` is unaffected.
- R9: When an undervoltage flag clears, a gate it blocked stays low even if its command is still high. The gate rises only after that command goes low and then high again.
- R10: `boot_en` equals `gate_lo` in every cycle.
- R11: Commands that alternate at a 400 kHz switching rate (500 cycles per period at 200 MHz) produce a full deadtime at every hand-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | 1 | Upper-switch command, active high |
| cmd_lo | input | 1 | Lower-switch command, active high |
| uv_lo | input | 1 | Lower supply undervoltage flag, high = fault |
| uv_hi | input | 1 | Floating supply undervoltage flag, high = fault |
| gate_hi | output | 1 | Upper gate enable |
| gate_lo | output | 1 | Lower gate enable |
| boot_en | output | 1 | Bootstrap-charging switch enable |

## Verification
The bench times the hand-off between sides to the exact cycle. A counter that is off by one, or that runs only for the same side, would let the incoming gate rise one cycle early or overlap the falling one. It pulses a command for less than the deadtime, so a design that latches the request would fire the gate late. It holds a command high across each undervoltage fault and its release, so a design that re-enables on level instead of edge would switch the bridge with no new command. It also drives both commands high with one side already on, then raises the first gate right after reset, and it alternates the commands at the maximum switching rate while a monitor measures every off-to-on gap.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;
  // Synchronizer depth for all asynchronous inputs
  localparam int unsigned SYNC_STAGES = 2;
  // Index of each side in per-side vectors
  localparam int unsigned SIDE_HI = 0;
  localparam int unsigned SIDE_LO = 1;
  localparam int unsigned NUM_SIDES = 2;

  typedef struct packed {
    logic uvh;
    logic uvl;
    logic lo;
    logic hi;
  } hb_inputs_t;
endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= '0;
      else        chain[b] <= {chain[b][STAGES-2:0], d_in[b]};
    end
    assign q_out[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/hbdt_arm.sv
module hbdt_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic block,
  output logic allow
);
  logic prev_q;
  logic armed_q;
  logic rise;

  // A fresh rising edge arms the side; a fault disarms it until the next edge
  assign rise  = cmd & ~prev_q;
  assign allow = (armed_q | rise) & cmd & ~block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cmd;
      armed_q <= allow;
    end
  end
endmodule

// File: rtl/hbdt_dt_timer.sv
module hbdt_dt_timer #(
  parameter int unsigned DT_CYCLES = 94
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_evt,
  output logic dt_done
);
  localparam int unsigned CW = $clog2(DT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DT_CYCLES);

  logic [CW-1:0] cnt_q;

  // cnt_q holds the number of low cycles elapsed since the last turn-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (off_evt)        cnt_q <= CW'(1);
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign dt_done = (cnt_q == LIMIT);
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hbdt_pkg::*;
#(
  parameter int unsigned DT_CYCLES = 94
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic uv_lo,
  input  logic uv_hi,
  output logic gate_hi,
  output logic gate_lo,
  output logic boot_en
);
  localparam int unsigned IN_W = $bits(hb_inputs_t);

  hb_inputs_t raw_in, syn_in;
  logic [NUM_SIDES-1:0] side_cmd, side_block, side_allow;
  logic req_hi, req_lo, hi_next, lo_next, off_evt, dt_done;
  logic gate_hi_q, gate_lo_q, boot_q;

  assign raw_in = '{uvh: uv_hi, uvl: uv_lo, lo: cmd_lo, hi: cmd_hi};

  hbdt_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .q_out (syn_in)
  );

  assign side_cmd[SIDE_HI]   = syn_in.hi;
  assign side_cmd[SIDE_LO]   = syn_in.lo;
  assign side_block[SIDE_HI] = syn_in.uvl | syn_in.uvh;
  assign side_block[SIDE_LO] = syn_in.uvl;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hbdt_arm u_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (side_cmd[s]),
      .block (side_block[s]),
      .allow (side_allow[s])
    );
  end

  // Both commands high: neither side is requested
  assign req_hi = side_allow[SIDE_HI] & ~syn_in.lo;
  assign req_lo = side_allow[SIDE_LO] & ~syn_in.hi;

  // A gate stays on while requested; it turns on only after the deadtime
  // and only while the opposite gate is off
  assign hi_next = gate_hi_q ? req_hi : (req_hi & dt_done & ~gate_lo_q);
  assign lo_next = gate_lo_q ? req_lo : (req_lo & dt_done & ~gate_hi_q);
  assign off_evt = (gate_hi_q & ~hi_next) | (gate_lo_q & ~lo_next);

  hbdt_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .off_evt (off_evt),
    .dt_done (dt_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
      boot_q    <= 1'b0;
    end else begin
      gate_hi_q <= hi_next;
      gate_lo_q <= lo_next;
      boot_q    <= lo_next;
    end
  end

  assign gate_hi = gate_hi_q;
  assign gate_lo = gate_lo_q;
  assign boot_en = boot_q;
endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker #(
  parameter int unsigned DT_CYCLES = 94
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_hi,
  input logic cmd_lo,
  input logic uv_lo,
  input logic uv_hi,
  input logic gate_hi,
  input logic gate_lo,
  input logic boot_en
);
  localparam int unsigned CW = $clog2(DT_CYCLES + 2);
  localparam logic [CW-1:0] CAP = CW'(DT_CYCLES);

  logic prev_hi, prev_lo;
  logic [CW-1:0] since_off;

  // Count the low cycles since the last observed turn-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi   <= 1'b0;
      prev_lo   <= 1'b0;
      since_off <= '0;
    end else begin
      prev_hi <= gate_hi;
      prev_lo <= gate_lo;
      if ((prev_hi & ~gate_hi) | (prev_lo & ~gate_lo)) since_off <= CW'(1);
      else if (since_off < CAP)                        since_off <= since_off + CW'(1);
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R3

  AST_BOTH_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_hi, 3) && $past(cmd_lo, 3)) |-> (!gate_hi && !gate_lo)); // R1

  AST_DT_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (since_off >= CAP)); // R4

  AST_DT_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (since_off >= CAP)); // R4

  AST_UVLO_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_lo, 3) |-> (!gate_hi && !gate_lo)); // R7

  AST_UVHI_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_hi, 3) |-> !gate_hi); // R8

  AST_BOOT_TRACKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    boot_en == gate_lo); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!gate_hi && !gate_lo && !boot_en)); // R6
endmodule

bind hb_deadtime_ctrl hbdt_checker #(.DT_CYCLES(DT_CYCLES)) u_hbdt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_hi  (cmd_hi),
  .cmd_lo  (cmd_lo),
  .uv_lo   (uv_lo),
  .uv_hi   (uv_hi),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .boot_en (boot_en)
);

// File: tb/tb_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module tb_hb_deadtime_ctrl;
  localparam int DT = 94;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0, uv_lo = 1'b0, uv_hi = 1'b0;
  logic gate_hi, gate_lo, boot_en;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl #(.DT_CYCLES(DT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .uv_lo(uv_lo), .uv_hi(uv_hi),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .boot_en(boot_en)
  );

  typedef struct {
    int    due;
    logic  eh;
    logic  el;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int ntest = 0;
  int nfail = 0;
  bit done = 0;
  logic ph = 1'b0, pl = 1'b0;
  int last_fall = 0;

  // Monitor: cycle count, scoreboard compare, gap measurement
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_fall = cyc;
      ph = 1'b0;
      pl = 1'b0;
    end else begin
      if ((ph && !gate_hi) || (pl && !gate_lo)) last_fall = cyc;
      if ((!ph && gate_hi) || (!pl && gate_lo)) begin
        ntest++;
        if (cyc - last_fall < DT) begin
          nfail++;
          $display("FAIL R4: off-to-on gap %0d cycles, expected >= %0d", cyc - last_fall, DT);
        end
        ntest++;
        if (gate_hi && gate_lo) begin
          nfail++;
          $display("FAIL R3: gate_hi/gate_lo=11 expected not both high");
        end
      end
      ph = gate_hi;
      pl = gate_lo;
    end
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      ntest++;
      if (gate_hi !== e.eh || gate_lo !== e.el) begin
        nfail++;
        $display("FAIL %s: gate_hi/gate_lo=%b%b expected %b%b (cycle %0d)",
                 e.tag, gate_hi, gate_lo, e.eh, e.el, cyc);
      end
      ntest++;
      if (boot_en !== e.el) begin
        nfail++;
        $display("FAIL R10: boot_en=%b expected %b (cycle %0d)", boot_en, e.el, cyc);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drive(input logic h, input logic l, input logic ul, input logic uh);
    step();
    cmd_hi = h;
    cmd_lo = l;
    uv_lo  = ul;
    uv_hi  = uh;
  endtask

  task automatic expect_at(input int k, input logic eh, input logic el, input string tag);
    exp_t e;
    e.due = cyc + k;
    e.eh  = eh;
    e.el  = el;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    // R6: reset state
    wait_n(3);
    ntest++;
    if (gate_hi !== 1'b0 || gate_lo !== 1'b0 || boot_en !== 1'b0) begin
      nfail++;
      $display("FAIL R6: outputs=%b%b%b expected 000 in reset", gate_hi, gate_lo, boot_en);
    end
    step();
    rst_n = 1'b1;
    cmd_hi = 1'b1;
    // R6: no gate in the first deadtime after reset
    expect_at(30, 0, 0, "R6");
    expect_at(DT, 0, 0, "R6");
    expect_at(DT + 1, 1, 0, "R6");
    wait_n(DT + 10);

    // R2: turn-off and turn-on latency of three edges
    drive(0, 0, 0, 0);
    expect_at(2, 1, 0, "R2");
    expect_at(3, 0, 0, "R2");
    wait_n(DT + 10);
    drive(1, 0, 0, 0);
    expect_at(2, 0, 0, "R2");
    expect_at(3, 1, 0, "R2");
    wait_n(10);

    // R4: hand-off from upper to lower, exact deadtime
    drive(0, 1, 0, 0);
    expect_at(3, 0, 0, "R4");
    expect_at(DT + 2, 0, 0, "R4");
    expect_at(DT + 3, 0, 1, "R4");
    wait_n(DT + 10);

    // R1: both commands high force both gates low
    drive(1, 1, 0, 0);
    expect_at(5, 0, 0, "R1");
    expect_at(DT + 20, 0, 0, "R1");
    wait_n(DT + 25);
    drive(0, 1, 0, 0);
    expect_at(3, 0, 1, "R1");
    wait_n(10);
    drive(0, 0, 0, 0);
    expect_at(3, 0, 0, "R1");
    wait_n(3);

    // R5: short upper pulse inside the deadtime is cancelled
    drive(1, 0, 0, 0);
    expect_at(10, 0, 0, "R5");
    expect_at(29, 0, 0, "R5");
    wait_n(30);
    cmd_hi = 1'b0;
    expect_at(DT, 0, 0, "R5");
    wait_n(DT + 10);

    // R7: lower-supply fault blocks both sides
    drive(1, 0, 0, 0);
    expect_at(3, 1, 0, "R1");
    wait_n(10);
    drive(1, 0, 1, 0);
    expect_at(3, 0, 0, "R7");
    wait_n(10);
    drive(0, 1, 1, 0);
    expect_at(DT + 10, 0, 0, "R7");
    wait_n(DT + 15);
    // R9: lower command held high across the fault stays blocked
    drive(0, 1, 0, 0);
    expect_at(DT + 10, 0, 0, "R9");
    wait_n(DT + 15);
    drive(0, 0, 0, 0);
    wait_n(5);
    drive(0, 1, 0, 0);
    expect_at(3, 0, 1, "R9");
    wait_n(10);

    // R8: floating-supply fault leaves the lower gate alone
    drive(0, 1, 0, 1);
    expect_at(10, 0, 1, "R8");
    wait_n(12);
    drive(1, 0, 0, 1);
    expect_at(DT + 10, 0, 0, "R8");
    wait_n(DT + 15);
    drive(1, 0, 0, 0);
    expect_at(DT, 0, 0, "R9");
    wait_n(DT + 5);
    drive(0, 0, 0, 0);
    wait_n(5);
    drive(1, 0, 0, 0);
    expect_at(3, 1, 0, "R9");
    wait_n(10);
    drive(1, 0, 0, 1);
    expect_at(3, 0, 0, "R8");
    wait_n(10);
    drive(0, 0, 0, 0);
    wait_n(DT + 10);

    // R11: alternate at the maximum switching rate
    for (int i = 0; i < 6; i++) begin
      drive(1, 0, 0, 0);
      expect_at(DT + 3, 1, 0, "R11");
      wait_n(249);
      drive(0, 1, 0, 0);
      if (i > 0) expect_at(DT + 2, 0, 0, "R11");
      expect_at(DT + 3, 0, 1, "R11");
      wait_n(249);
    end
    drive(0, 0, 0, 0);
    wait_n(10);

    while (q.size() > 0) step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntest++;
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule